// File: doc/BRIEF.md
# Interrupt-to-Vector Message Bridge

This block gathers 64 device interrupt lines and converts each one that is active, enabled for conversion and not masked into a single message for a host-side vector controller. Each message carries two bytes that software assigned to the source: a vector number and a route selector. Software reaches the block through a 32-bit word-addressed register port. That port holds a set of per-source bitmaps (mask, conversion enable, trigger kind, polarity, and two stored-only bounce words), a write-one-to-clear word pair, and the two per-source byte tables.

Each source is either edge-triggered or level-triggered, and its polarity is chosen per source. An edge source latches a pending flag when its selected edge arrives. A level source is pending for as long as its input sits at the active level. A source that has had a message accepted enters service and stays there until software writes a 1 to its clear bit. During that time the source cannot send again, whatever its input does. When several sources can send, the lowest-numbered one goes first. A message is offered with a valid/ready handshake and is held unchanged until it is accepted.

Top module: `irq_msg_bridge`

## Requirements
- R1: After synchronous reset every readable register reads 0 and `msg_valid` is low.
- R2: The per-source bitmaps are 64 bits wide, stored as two 32-bit words at consecutive word offsets. Source n sits in word n/32, bit n%32. The offsets are: mask 0x20/0x24, conversion enable 0x40/0x44, trigger kind 0x60/0x64, polarity 0x3E0/0x3E4, and the two stored bounce words 0xC0/0xC4 and 0xE0/0xE4. Writes update only the byte lanes whose `reg_be` bit is set, and reads return the stored value. The bounce words change no behaviour. The clear words at 0x80/0x84 always read 0.
- R3: The route byte of source n is byte lane n%4 of the word at 0x100+4*(n/4). The vector byte of source n is the same lane of the word at 0x200+4*(n/4). Each byte is written only when its lane enable is set.
- R4: The trigger/polarity bit pair selects the detection: (1,0) rising edge, (1,1) falling edge, (0,0) active-high level, (0,1) active-low level. An edge source sets a latched pending flag on its edge. A level source is pending while its input is at the active level.
- R5: A source can send only while its enable bit is 1 and its mask bit is 0. An edge latched while the source is blocked stays pending and is sent once the source is unblocked.
- R6: A source sends exactly one message and then stays in service until a 1 is written to its bit in the clear words. That write also drops any latched edge. Writing 0 to a clear bit has no effect.
- R7: Each message carries the vector byte and the route byte of the source it stands for.
- R8: When several sources can send, the lowest-numbered one is offered first. An offered message is not replaced by a lower-numbered source that arrives later.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_route` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte lane enables for writes |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_in | input | 64 | Device interrupt lines, synchronous to `clk` |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The host accepts the offered message |
| msg_vector | output | 8 | Vector byte of the offered message |
| msg_route | output | 8 | Route byte of the offered message |

## Verification
Each of the four detection kinds gets its own stimulus: a single-cycle pulse and a held-high input for the rising edge, a rise-then-fall for the falling edge, and inputs held across clear writes for both level kinds. Together these show which input history counts as pending and which does not. Sources that become eligible together within one mask word show the lowest-first order. A lower source that rises while the host withholds ready shows that an offered message is neither preempted nor altered. Edges that arrive while the source is masked or disabled, and clear writes of 0 against clear writes of 1, separate a blocked latch from a discarded one and show that only a 1 ends service.

// File: rtl/irq_msg_pkg.sv
// Package: irq_msg_pkg
// Shared register offsets and the message type of the interrupt-to-vector
// bridge. Offsets are byte addresses of the first word of each region; the
// second word of a bitmap sits 4 bytes above the first.
package irq_msg_pkg;

    localparam int OFS_MASK  = 32'h020;
    localparam int OFS_MSGEN = 32'h040;
    localparam int OFS_TRIG  = 32'h060;
    localparam int OFS_CLR   = 32'h080;
    localparam int OFS_BNC0  = 32'h0C0;
    localparam int OFS_BNC1  = 32'h0E0;
    localparam int OFS_ROUTE = 32'h100;
    localparam int OFS_VECT  = 32'h200;
    localparam int OFS_POL   = 32'h3E0;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] msg_byte_t;

    typedef struct packed {
        msg_byte_t vector;
        msg_byte_t route;
    } msg_t;

endpackage

// File: rtl/irq_msg_regs.sv
// Module: irq_msg_regs
// Register file of the bridge. Holds the per-source bitmaps, the stored-only
// bounce words and the per-source route/vector byte tables. Produces a
// one-cycle clear pulse per source for write-one-to-clear writes.
// Assumes: N_SRC is a multiple of DW, DW is a multiple of 8, the address
// decode sees aligned word addresses, and reads are combinational.
module irq_msg_regs
    import irq_msg_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [DW/8-1:0]       be,
    output logic [DW-1:0]         rdata,
    output logic [N_SRC-1:0]      mask_bits,
    output logic [N_SRC-1:0]      en_bits,
    output logic [N_SRC-1:0]      trig_bits,
    output logic [N_SRC-1:0]      pol_bits,
    output logic [N_SRC-1:0]      clr_pulse,
    output msg_byte_t [N_SRC-1:0] route_bytes,
    output msg_byte_t [N_SRC-1:0] vect_bytes
);

    localparam int WORDS  = N_SRC / DW;
    localparam int LANES  = DW / BYTE_W;
    localparam int BWORDS = N_SRC / LANES;

    logic [WORDS-1:0][DW-1:0] mask_q, en_q, trig_q, pol_q, bnc0_q, bnc1_q;
    logic [WORDS-1:0][DW-1:0] clr_w;
    msg_byte_t [N_SRC-1:0]    route_q, vect_q;
    logic [DW-1:0]            bmask;

    // Expand the byte lane enables into a bit mask.
    always_comb begin : lane_expand
        for (int l = 0; l < LANES; l++) begin
            bmask[l*BYTE_W +: BYTE_W] = {BYTE_W{be[l]}};
        end
    end

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v);
        return (old_v & ~bmask) | (wdata & bmask);
    endfunction

    // Bitmap word writes with byte lane enables.
    always_ff @(posedge clk) begin : bitmap_write
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
            trig_q <= '0;
            pol_q  <= '0;
            bnc0_q <= '0;
            bnc1_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (addr == AW'(OFS_MASK  + 4*w)) mask_q[w] <= merge(mask_q[w]);
                if (addr == AW'(OFS_MSGEN + 4*w)) en_q[w]   <= merge(en_q[w]);
                if (addr == AW'(OFS_TRIG  + 4*w)) trig_q[w] <= merge(trig_q[w]);
                if (addr == AW'(OFS_POL   + 4*w)) pol_q[w]  <= merge(pol_q[w]);
                if (addr == AW'(OFS_BNC0  + 4*w)) bnc0_q[w] <= merge(bnc0_q[w]);
                if (addr == AW'(OFS_BNC1  + 4*w)) bnc1_q[w] <= merge(bnc1_q[w]);
            end
        end
    end

    // Per-source route and vector byte writes, one lane per source.
    always_ff @(posedge clk) begin : byte_table_write
        if (!rst_n) begin
            route_q <= '0;
            vect_q  <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < N_SRC; n++) begin
                if (be[n % LANES] && addr == AW'(OFS_ROUTE + 4*(n / LANES)))
                    route_q[n] <= wdata[(n % LANES)*BYTE_W +: BYTE_W];
                if (be[n % LANES] && addr == AW'(OFS_VECT + 4*(n / LANES)))
                    vect_q[n] <= wdata[(n % LANES)*BYTE_W +: BYTE_W];
            end
        end
    end

    // Write-one-to-clear decode: a pulse for each written 1 in an enabled lane.
    always_comb begin : clear_decode
        clr_w = '0;
        if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (addr == AW'(OFS_CLR + 4*w)) clr_w[w] = wdata & bmask;
            end
        end
    end

    // Read multiplexer; unmapped words and the clear words read 0.
    always_comb begin : read_mux
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == AW'(OFS_MASK  + 4*w)) rdata = mask_q[w];
            if (addr == AW'(OFS_MSGEN + 4*w)) rdata = en_q[w];
            if (addr == AW'(OFS_TRIG  + 4*w)) rdata = trig_q[w];
            if (addr == AW'(OFS_POL   + 4*w)) rdata = pol_q[w];
            if (addr == AW'(OFS_BNC0  + 4*w)) rdata = bnc0_q[w];
            if (addr == AW'(OFS_BNC1  + 4*w)) rdata = bnc1_q[w];
        end
        for (int k = 0; k < BWORDS; k++) begin
            if (addr == AW'(OFS_ROUTE + 4*k)) begin
                for (int l = 0; l < LANES; l++) rdata[l*BYTE_W +: BYTE_W] = route_q[k*LANES + l];
            end
            if (addr == AW'(OFS_VECT + 4*k)) begin
                for (int l = 0; l < LANES; l++) rdata[l*BYTE_W +: BYTE_W] = vect_q[k*LANES + l];
            end
        end
    end

    assign mask_bits   = mask_q;
    assign en_bits     = en_q;
    assign trig_bits   = trig_q;
    assign pol_bits    = pol_q;
    assign clr_pulse   = clr_w;
    assign route_bytes = route_q;
    assign vect_bytes  = vect_q;

endmodule

// File: rtl/irq_msg_detect.sv
// Module: irq_msg_detect
// Per-source detection and service tracking. Edge sources latch a pending
// flag on the selected edge; level sources are pending while at the active
// level. A source whose message was accepted stays in service until cleared.
// Assumes: irq_in is already synchronous to clk; accept is one-hot or zero.
module irq_msg_detect #(
    parameter int N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [N_SRC-1:0] trig_bits,
    input  logic [N_SRC-1:0] pol_bits,
    input  logic [N_SRC-1:0] clr_pulse,
    input  logic [N_SRC-1:0] accept,
    output logic [N_SRC-1:0] cand_bits,
    output logic [N_SRC-1:0] sent_bits
);

    logic [N_SRC-1:0] prev_q, pend_q, sent_q;
    logic [N_SRC-1:0] edge_hit, level_act, pending;

    // Selected edge: rising for polarity 0, falling for polarity 1.
    assign edge_hit  = (~pol_bits & irq_in & ~prev_q) | (pol_bits & ~irq_in & prev_q);
    assign level_act = irq_in ^ pol_bits;
    assign pending   = (trig_bits & pend_q) | (~trig_bits & level_act);

    // Input history, latched edges and in-service flags; a new edge or an
    // acceptance in the same cycle as a clear survives the clear.
    always_ff @(posedge clk) begin : source_state
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            sent_q <= '0;
        end else begin
            prev_q <= irq_in;
            pend_q <= (pend_q & ~clr_pulse) | (trig_bits & edge_hit);
            sent_q <= (sent_q & ~clr_pulse) | accept;
        end
    end

    assign cand_bits = pending & ~sent_q;
    assign sent_bits = sent_q;

endmodule

// File: rtl/irq_msg_arbiter.sv
// Module: irq_msg_arbiter
// Picks the lowest-numbered eligible source while no message is offered,
// registers its vector and route bytes, and holds them until accepted.
// Assumes: one idle cycle after each acceptance is acceptable.
module irq_msg_arbiter
    import irq_msg_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int IDXW  = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      elig_bits,
    input  msg_byte_t [N_SRC-1:0] route_bytes,
    input  msg_byte_t [N_SRC-1:0] vect_bytes,
    input  logic                  msg_ready,
    output logic                  msg_valid,
    output msg_t                  msg_out,
    output logic [IDXW-1:0]       msg_idx,
    output logic [N_SRC-1:0]      accept
);

    logic [IDXW-1:0] pick;
    logic            any;

    // Lowest-index priority encoder.
    always_comb begin : lowest_pick
        pick = '0;
        any  = |elig_bits;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig_bits[i]) pick = IDXW'(i);
        end
    end

    // Offer register: load when idle, hold until the handshake completes.
    always_ff @(posedge clk) begin : offer_reg
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_out   <= '0;
            msg_idx   <= '0;
        end else if (!msg_valid) begin
            if (any) begin
                msg_valid      <= 1'b1;
                msg_idx        <= pick;
                msg_out.vector <= vect_bytes[pick];
                msg_out.route  <= route_bytes[pick];
            end
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // One-hot acceptance strobe back to the service tracking.
    always_comb begin : accept_strobe
        accept = '0;
        if (msg_valid && msg_ready) accept[msg_idx] = 1'b1;
    end

endmodule

// File: rtl/irq_msg_bridge.sv
// Module: irq_msg_bridge
// Top of the interrupt-to-vector bridge: register file, per-source
// detection and the message arbiter. A source is eligible when it is a
// candidate (pending, not in service), enabled and not masked.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module irq_msg_bridge
    import irq_msg_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [DW/8-1:0]  reg_be,
    output logic [DW-1:0]    reg_rdata,
    input  logic [N_SRC-1:0] irq_in,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [7:0]       msg_vector,
    output logic [7:0]       msg_route
);

    localparam int IDXW = $clog2(N_SRC);

    logic [N_SRC-1:0]      mask_bits, en_bits, trig_bits, pol_bits, clr_pulse;
    logic [N_SRC-1:0]      cand_bits, sent_bits, elig_bits, accept;
    msg_byte_t [N_SRC-1:0] route_bytes, vect_bytes;
    msg_t                  msg_out;
    logic [IDXW-1:0]       msg_idx;

    irq_msg_regs #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .be         (reg_be),
        .rdata      (reg_rdata),
        .mask_bits  (mask_bits),
        .en_bits    (en_bits),
        .trig_bits  (trig_bits),
        .pol_bits   (pol_bits),
        .clr_pulse  (clr_pulse),
        .route_bytes(route_bytes),
        .vect_bytes (vect_bytes)
    );

    irq_msg_detect #(.N_SRC(N_SRC)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .trig_bits(trig_bits),
        .pol_bits (pol_bits),
        .clr_pulse(clr_pulse),
        .accept   (accept),
        .cand_bits(cand_bits),
        .sent_bits(sent_bits)
    );

    // Gate candidates by conversion enable and mask.
    assign elig_bits = cand_bits & en_bits & ~mask_bits;

    irq_msg_arbiter #(.N_SRC(N_SRC), .IDXW(IDXW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_bits  (elig_bits),
        .route_bytes(route_bytes),
        .vect_bytes (vect_bytes),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_out    (msg_out),
        .msg_idx    (msg_idx),
        .accept     (accept)
    );

    assign msg_vector = msg_out.vector;
    assign msg_route  = msg_out.route;

endmodule

// File: rtl/irq_msg_checker.sv
// Module: irq_msg_checker
// Temporal checks on the bridge, bound into irq_msg_bridge. Keeps a
// one-cycle copy of the eligibility inputs so that each newly offered
// message can be compared with the state the choice was made from.
module irq_msg_checker #(
    parameter int N_SRC = 64,
    parameter int IDXW  = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_vector,
    input logic [7:0]       msg_route,
    input logic [IDXW-1:0]  msg_idx,
    input logic [N_SRC-1:0] elig_bits,
    input logic [N_SRC-1:0] en_bits,
    input logic [N_SRC-1:0] mask_bits,
    input logic [N_SRC-1:0] sent_bits
);

    logic [N_SRC-1:0] prev_open, prev_elig, prev_sent, below;

    // Copy of the arbiter's inputs from the cycle the offer was loaded.
    always_ff @(posedge clk) begin : history
        if (!rst_n) begin
            prev_open <= '0;
            prev_elig <= '0;
            prev_sent <= '0;
        end else begin
            prev_open <= en_bits & ~mask_bits;
            prev_elig <= elig_bits;
            prev_sent <= sent_bits;
        end
    end

    assign below = (N_SRC'(1) << msg_idx) - N_SRC'(1);

    // R5: a new offer comes from an enabled, unmasked source.
    p_pick_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> prev_open[msg_idx]);

    // R6: a new offer never comes from a source already in service.
    p_not_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !prev_sent[msg_idx]);

    // R6: an accepted source is in service afterwards.
    p_accept_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> sent_bits[$past(msg_idx)]);

    // R8: no lower-numbered source was eligible when the offer was loaded.
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ((prev_elig & below) == '0));

    // R9: a stalled offer is held unchanged.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_route) && $stable(msg_idx)));

endmodule

bind irq_msg_bridge irq_msg_checker #(.N_SRC(N_SRC), .IDXW(IDXW)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_vector(msg_vector),
    .msg_route (msg_route),
    .msg_idx   (msg_idx),
    .elig_bits (elig_bits),
    .en_bits   (en_bits),
    .mask_bits (mask_bits),
    .sent_bits (sent_bits)
);

// File: tb/irq_msg_bridge_bench.sv
// Bench: scoreboard driven. Driver tasks push the expected {vector, route}
// pairs into a queue; a monitor pops and compares on each handshake.
module irq_msg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic [63:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_vector, msg_route;

    int n_checks = 0;
    int n_fail   = 0;
    int n_msgs   = 0;
    bit done     = 1'b0;
    logic [15:0] exp_q[$];
    logic [63:0] sh_mask = '0, sh_en = '0, sh_trig = '0, sh_pol = '0;

    always #4 clk = ~clk;  // 125 MHz

    irq_msg_bridge u_irq_msg_bridge (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_route(msg_route)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] vec_of(input int n);
        return 8'(8'h40 + n);
    endfunction

    function automatic logic [7:0] route_of(input int n);
        return 8'(n * 3 + 1);
    endfunction

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 12'(a);
        #2 d = reg_rdata;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d == exp, req, $sformatf("read 0x%0h", a), d, exp);
    endtask

    task automatic put_bitmap(input int base, input logic [63:0] v);
        wr(base, v[31:0]);
        wr(base + 4, v[63:32]);
    endtask

    // R3: route/vector bytes written through their own lane only.
    task automatic cfg_src(input int n, input bit trig, input bit pol);
        wr(32'h100 + 4*(n/4), 32'(route_of(n)) << (8*(n%4)), 4'(1 << (n%4)));
        wr(32'h200 + 4*(n/4), 32'(vec_of(n)) << (8*(n%4)), 4'(1 << (n%4)));
        sh_trig[n] = trig; sh_pol[n] = pol;
        put_bitmap(32'h60, sh_trig);
        put_bitmap(32'h3E0, sh_pol);
    endtask

    task automatic set_en(input int n, input bit v);
        sh_en[n] = v; put_bitmap(32'h40, sh_en);
    endtask

    task automatic set_mask(input int n, input bit v);
        sh_mask[n] = v; put_bitmap(32'h20, sh_mask);
    endtask

    task automatic set_irq(input int n, input bit v);
        @(negedge clk); irq_in[n] = v;
    endtask

    task automatic clr_src(input int n);
        wr(32'h80 + 4*(n/32), 32'h1 << (n%32));
    endtask

    task automatic expect_msg(input int n);
        exp_q.push_back({vec_of(n), route_of(n)});
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected messages outstanding", exp_q.size(), 0);
    endtask

    task automatic quiet(input int cyc, input string req);
        int m0;
        m0 = n_msgs;
        repeat (cyc) @(negedge clk);
        chk(n_msgs == m0, req, "messages in quiet window", n_msgs - m0, 0);
    endtask

    // Monitor: compare each accepted message with the scoreboard head (R7, R8).
    always begin
        @(negedge clk);
        #2;
        if (rst_n && msg_valid && msg_ready) begin
            n_msgs++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected message", {msg_vector, msg_route}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({msg_vector, msg_route} == e, "R7 R8", "message bytes",
                    {msg_vector, msg_route}, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] hv, hr;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        #2 chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
        rd_chk(32'h20, 32'h0, "R1");
        rd_chk(32'h44, 32'h0, "R1");
        rd_chk(32'h204, 32'h0, "R1");
        rd_chk(32'h3E4, 32'h0, "R1");

        // R2: bitmap access with byte lanes, clear and bounce words.
        wr(32'h24, 32'hA5A5_0F0F);
        rd_chk(32'h24, 32'hA5A5_0F0F, "R2");
        wr(32'h60, 32'hFFFF_FFFF, 4'b0010);
        rd_chk(32'h60, 32'h0000_FF00, "R2");
        wr(32'h60, 32'h0);
        wr(32'h24, 32'h0);
        wr(32'h80, 32'hFFFF_FFFF);
        rd_chk(32'h80, 32'h0, "R2");
        wr(32'hC0, 32'hFFFF_FFFF);
        wr(32'hE4, 32'h1234_5678);
        rd_chk(32'hC0, 32'hFFFF_FFFF, "R2");
        rd_chk(32'hE4, 32'h1234_5678, "R2");

        // R3: a single byte lane of the route table.
        wr(32'h104, 32'h0000_7700, 4'b0010);
        rd_chk(32'h104, 32'h0000_7700, "R3");
        wr(32'h204, 32'h0000_00EE, 4'b0001);
        rd_chk(32'h204, 32'h0000_00EE, "R3");

        // Start-up: mask and clear everything.
        sh_mask = '1;
        put_bitmap(32'h20, sh_mask);
        put_bitmap(32'h80, '1);

        // R4 level high on source 3, R6 service and clear.
        cfg_src(3, 1'b0, 1'b0);
        set_en(3, 1'b1);
        set_mask(3, 1'b0);
        quiet(8, "R4");
        expect_msg(3);
        set_irq(3, 1'b1);
        drain("R4");
        quiet(10, "R6");
        wr(32'h80, 32'h0);
        quiet(10, "R6");
        expect_msg(3);
        clr_src(3);
        drain("R6");
        set_irq(3, 1'b0);
        clr_src(3);
        quiet(10, "R4");

        // R4 level low on source 40 (upper word).
        cfg_src(40, 1'b0, 1'b1);
        set_irq(40, 1'b1);
        set_en(40, 1'b1);
        set_mask(40, 1'b0);
        quiet(8, "R4");
        expect_msg(40);
        set_irq(40, 1'b0);
        drain("R4");
        set_irq(40, 1'b1);
        clr_src(40);
        quiet(8, "R4");

        // R4 rising edge on source 5.
        cfg_src(5, 1'b1, 1'b0);
        set_en(5, 1'b1);
        set_mask(5, 1'b0);
        expect_msg(5);
        set_irq(5, 1'b1);
        set_irq(5, 1'b0);
        drain("R4");
        clr_src(5);
        quiet(8, "R4");
        expect_msg(5);
        set_irq(5, 1'b1);
        drain("R4");
        clr_src(5);
        quiet(10, "R4");
        set_irq(5, 1'b0);
        quiet(6, "R4");

        // R5: edge latched while masked is sent on unmask.
        set_mask(5, 1'b1);
        set_irq(5, 1'b1);
        set_irq(5, 1'b0);
        quiet(8, "R5");
        expect_msg(5);
        set_mask(5, 1'b0);
        drain("R5");
        clr_src(5);

        // R4 falling edge on source 6.
        cfg_src(6, 1'b1, 1'b1);
        set_en(6, 1'b1);
        set_mask(6, 1'b0);
        set_irq(6, 1'b1);
        quiet(8, "R4");
        expect_msg(6);
        set_irq(6, 1'b0);
        drain("R4");
        clr_src(6);

        // R5: enable and mask gating on level source 7.
        cfg_src(7, 1'b0, 1'b0);
        set_mask(7, 1'b0);
        set_irq(7, 1'b1);
        quiet(8, "R5");
        set_mask(7, 1'b1);
        set_en(7, 1'b1);
        quiet(8, "R5");
        expect_msg(7);
        set_mask(7, 1'b0);
        drain("R5");
        set_irq(7, 1'b0);
        clr_src(7);

        // R8: three sources unmasked by one write, lowest first.
        cfg_src(20, 1'b0, 1'b0);
        cfg_src(2, 1'b0, 1'b0);
        cfg_src(10, 1'b0, 1'b0);
        set_en(20, 1'b1); set_en(2, 1'b1); set_en(10, 1'b1);
        set_irq(20, 1'b1); set_irq(2, 1'b1); set_irq(10, 1'b1);
        quiet(6, "R8");
        expect_msg(2); expect_msg(10); expect_msg(20);
        sh_mask[2] = 1'b0; sh_mask[10] = 1'b0; sh_mask[20] = 1'b0;
        wr(32'h20, sh_mask[31:0]);
        drain("R8");
        set_irq(20, 1'b0); set_irq(2, 1'b0); set_irq(10, 1'b0);
        wr(32'h80, 32'h0010_0404);

        // R9: stalled offer held; a later lower source waits (R8).
        msg_ready = 1'b0;
        cfg_src(12, 1'b0, 1'b0);
        cfg_src(1, 1'b0, 1'b0);
        set_en(12, 1'b1); set_en(1, 1'b1);
        set_mask(12, 1'b0); set_mask(1, 1'b0);
        set_irq(12, 1'b1);
        for (int i = 0; i < 20 && !msg_valid; i++) @(negedge clk);
        #2 chk(msg_valid == 1'b1, "R9", "offer present", msg_valid, 1);
        hv = msg_vector; hr = msg_route;
        chk({hv, hr} == {vec_of(12), route_of(12)}, "R7", "held bytes", {hv, hr},
            {vec_of(12), route_of(12)});
        set_irq(1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #2 chk(msg_valid && msg_vector == hv && msg_route == hr, "R9",
                   "held offer", {msg_valid, msg_vector, msg_route}, {1'b1, hv, hr});
        end
        expect_msg(12); expect_msg(1);
        @(negedge clk);
        msg_ready = 1'b1;
        drain("R8");
        set_irq(12, 1'b0); set_irq(1, 1'b0);
        clr_src(12); clr_src(1);
        quiet(8, "R6");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule